// File: doc/BRIEF.md
# Mixed-Mode BIST Seed Expansion Controller

This block drives a reseedable linear feedback shift register (LFSR) for mixed-mode logic self-test. A seed source hands it an ordered list of seeds over a valid/ready handshake. The block loads each accepted seed into the LFSR in parallel, then clocks the LFSR to shift a budget of scan patterns into a set of parallel scan chains. Each pattern is a burst of shift cycles with scan-enable high, followed by a single capture cycle.

A session opens with a start pulse. That pulse samples a schedule selector and an expansion depth, and both hold for the whole session. The uniform schedule expands every seed into the same short run. The two front-loaded schedules give a long pseudo-random run only to the first seed, or only to the first two seeds. Every later seed then yields exactly one deterministic pattern. An all-zero seed would lock the LFSR, so the block refuses it: it raises a sticky error flag and skips that seed. After the final seed has spent its budget, a done flag rises and stays up until the next start pulse or reset.

The controller is a five-state machine. **IDLE** is the state after reset. **WAIT_SEED** holds seed-ready high. **SHIFT** streams chain bits. **CAPT** is the capture cycle. **DONE** ends the session. Its transitions are listed below.
- IDLE→WAIT_SEED on start.
- WAIT_SEED→SHIFT on a nonzero seed.
- WAIT_SEED→WAIT_SEED on a zero seed that is not marked last.
- WAIT_SEED→DONE on a zero seed marked last.
- SHIFT→CAPT after the last shift cycle.
- CAPT→SHIFT while patterns remain.
- CAPT→WAIT_SEED when the budget is spent and the seed is not the last.
- CAPT→DONE when the budget is spent on the last seed.
- DONE→WAIT_SEED on start.

Top module: `mmbist_seed_ctrl`

## Requirements
- R1: After reset the following outputs are low: seed_ready, scan_en, capture, pat_done, all_done, seed_err and every scan_in bit. Only a start pulse leaves this condition.
- R2: The mode and depth inputs are captured on the start pulse. Later changes to them do not alter the pattern counts of that session. The cycle after start, seed_ready is high.
- R3: Mode encoding is 2'b00 uniform, 2'b01 first-seed-long, 2'b10 first-two-long, and 2'b11 behaves as uniform. In uniform mode every accepted seed yields depth patterns. A depth of 0 counts as 1.
- R4: In mode 2'b01 the first accepted nonzero seed yields depth patterns and every later seed yields exactly one.
- R5: In mode 2'b10 the first two accepted nonzero seeds yield depth patterns each and every later seed yields exactly one.
- R6: Each pattern is SHIFT_LEN = ceil(LFSR_W/CHAINS) consecutive cycles with scan_en high, then one cycle with capture high and scan_en low. pat_done pulses for one cycle, in the cycle right after each capture.
- R7: An accepted nonzero seed appears in the LFSR in the first shift cycle. The register is stepped once per shift cycle and runs on across the patterns of the same seed. The step shifts left and inserts the XOR of the state bits selected by TAPS at bit 0. Chain c receives state[c*STRIDE] XOR state[LFSR_W-1-c*STRIDE], with STRIDE = floor(LFSR_W/CHAINS).
- R8: seed_ready is high only in WAIT_SEED. It stays low from the acceptance of a nonzero seed until that seed's budget has been captured.
- R9: An all-zero seed is accepted but not loaded and produces no pattern. It does not count toward the first/second-seed positions of R4 and R5. It sets seed_err, which holds until the next start or reset.
- R10: The cycle after the capture that ends the budget of a seed marked last, all_done rises. It holds with seed_ready low until a start pulse, which clears it in the following cycle.
- R11: A zero seed marked last ends the session at once: all_done rises the next cycle and no pattern is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Session start pulse, honoured in IDLE and DONE |
| mode | input | 2 | Expansion schedule selector |
| depth | input | CNT_W | Expansion depth d |
| seed_valid | input | 1 | Seed offered |
| seed_data | input | LFSR_W | Seed value |
| seed_last | input | 1 | Marks the final seed of the list |
| seed_ready | output | 1 | Controller can accept a seed |
| scan_in | output | CHAINS | One bit per scan chain, zero outside shift |
| scan_en | output | 1 | Scan shift enable |
| capture | output | 1 | Capture strobe |
| pat_done | output | 1 | One-cycle pulse after each capture |
| seed_err | output | 1 | Sticky flag: an all-zero seed was refused |
| all_done | output | 1 | Session finished, held until start |

## Verification
The assertions take the following for granted: start arrives only in IDLE or DONE, and the seed source holds seed_valid and its data steady until a cycle with seed_ready high has passed. The stimulus keeps within these limits in two ways. It raises start only after reset or after all_done is seen. It drops seed_valid only on the edge that follows a sampled seed_ready. Under those conditions the sticky-error and done-hold properties depend only on start being absent.

// File: rtl/mmbist_pkg.sv
package mmbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SEED,
        ST_SHIFT,
        ST_CAPT,
        ST_DONE
    } ctrl_state_e;

    typedef enum logic [1:0] {
        MODE_UNIFORM = 2'b00,
        MODE_FIRST1  = 2'b01,
        MODE_FIRST2  = 2'b10,
        MODE_RSVD    = 2'b11
    } sched_mode_e;

endpackage

// File: rtl/mmbist_lfsr.sv
module mmbist_lfsr #(
    parameter int              W    = 96,
    parameter logic [W-1:0]    TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] st_q;
    logic         fb;

    always_comb begin
        fb = ^(st_q & TAPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= seed;
        end else if (step) begin
            st_q <= {st_q[W-2:0], fb};
        end
    end

    assign state = st_q;

endmodule

// File: rtl/mmbist_spread.sv
module mmbist_spread #(
    parameter int W      = 96,
    parameter int CHAINS = 8
) (
    input  logic [W-1:0]      state,
    input  logic              enable,
    output logic [CHAINS-1:0] chain_bits
);

    localparam int STRIDE = W / CHAINS;

    for (genvar c = 0; c < CHAINS; c++) begin : g_chain
        localparam int IDX_LO = c * STRIDE;
        localparam int IDX_HI = W - 1 - c * STRIDE;
        assign chain_bits[c] = enable & (state[IDX_LO] ^ state[IDX_HI]);
    end

endmodule

// File: rtl/mmbist_budget.sv
module mmbist_budget #(
    parameter int CNT_W = 13
) (
    input  mmbist_pkg::sched_mode_e mode,
    input  logic [1:0]              seed_idx,
    input  logic [CNT_W-1:0]        depth,
    output logic [CNT_W-1:0]        budget
);

    import mmbist_pkg::*;

    logic [CNT_W-1:0] d_eff;
    logic [CNT_W-1:0] one;

    always_comb begin
        one   = {{(CNT_W-1){1'b0}}, 1'b1};
        d_eff = (depth == '0) ? one : depth;
        unique case (mode)
            MODE_FIRST1: budget = (seed_idx == 2'd0) ? d_eff : one;
            MODE_FIRST2: budget = (seed_idx <  2'd2) ? d_eff : one;
            default:     budget = d_eff;
        endcase
    end

endmodule

// File: rtl/mmbist_seed_ctrl.sv
module mmbist_seed_ctrl #(
    parameter int                 LFSR_W = 96,
    parameter int                 CHAINS = 8,
    parameter int                 CNT_W  = 13,
    parameter logic [LFSR_W-1:0]  TAPS   = {4'b1101, {(LFSR_W-10){1'b0}}, 6'b000001}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  depth,
    input  logic              seed_valid,
    input  logic [LFSR_W-1:0] seed_data,
    input  logic              seed_last,
    output logic              seed_ready,
    output logic [CHAINS-1:0] scan_in,
    output logic              scan_en,
    output logic              capture,
    output logic              pat_done,
    output logic              seed_err,
    output logic              all_done
);

    import mmbist_pkg::*;

    localparam int SHIFT_LEN = (LFSR_W + CHAINS - 1) / CHAINS;
    localparam int SH_W      = $clog2(SHIFT_LEN + 1);
    localparam logic [SH_W-1:0] SH_LAST = SH_W'(SHIFT_LEN - 1);

    ctrl_state_e      state_q, state_d;
    sched_mode_e      mode_q;
    logic [CNT_W-1:0] depth_q;
    logic [1:0]       seed_idx_q;
    logic [CNT_W-1:0] pat_left_q;
    logic [SH_W-1:0]  sh_cnt_q;
    logic             last_q;
    logic             err_q;
    logic             pdone_q;

    logic             take_seed;
    logic             seed_zero;
    logic             load_seed;
    logic             start_ok;
    logic             budget_end;
    logic [CNT_W-1:0] budget;
    logic [LFSR_W-1:0] lfsr_state;
    logic [CHAINS-1:0] chain_bits;

    assign seed_zero  = (seed_data == '0);
    assign take_seed  = (state_q == ST_WAIT_SEED) && seed_valid;
    assign load_seed  = take_seed && !seed_zero;
    assign start_ok   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign budget_end = (pat_left_q == {{(CNT_W-1){1'b0}}, 1'b1});

    mmbist_budget #(.CNT_W(CNT_W)) u_budget (
        .mode     (mode_q),
        .seed_idx (seed_idx_q),
        .depth    (depth_q),
        .budget   (budget)
    );

    mmbist_lfsr #(.W(LFSR_W), .TAPS(TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_seed),
        .seed  (seed_data),
        .step  (state_q == ST_SHIFT),
        .state (lfsr_state)
    );

    mmbist_spread #(.W(LFSR_W), .CHAINS(CHAINS)) u_spread (
        .state      (lfsr_state),
        .enable     (state_q == ST_SHIFT),
        .chain_bits (chain_bits)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_SEED;
            end
            ST_WAIT_SEED: begin
                if (seed_valid) begin
                    if (!seed_zero)     state_d = ST_SHIFT;
                    else if (seed_last) state_d = ST_DONE;
                end
            end
            ST_SHIFT: begin
                if (sh_cnt_q == SH_LAST) state_d = ST_CAPT;
            end
            ST_CAPT: begin
                if (!budget_end)  state_d = ST_SHIFT;
                else if (last_q)  state_d = ST_DONE;
                else              state_d = ST_WAIT_SEED;
            end
            ST_DONE: begin
                if (start) state_d = ST_WAIT_SEED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_UNIFORM;
            depth_q    <= '0;
            seed_idx_q <= '0;
            pat_left_q <= '0;
            sh_cnt_q   <= '0;
            last_q     <= 1'b0;
            err_q      <= 1'b0;
            pdone_q    <= 1'b0;
        end else begin
            pdone_q <= (state_q == ST_CAPT);
            if (start_ok) begin
                mode_q     <= sched_mode_e'(mode);
                depth_q    <= depth;
                seed_idx_q <= '0;
                err_q      <= 1'b0;
            end
            if (take_seed && seed_zero) begin
                err_q <= 1'b1;
            end
            if (load_seed) begin
                pat_left_q <= budget;
                last_q     <= seed_last;
                sh_cnt_q   <= '0;
            end
            if (state_q == ST_SHIFT) begin
                sh_cnt_q <= (sh_cnt_q == SH_LAST) ? '0 : sh_cnt_q + 1'b1;
            end
            if (state_q == ST_CAPT) begin
                pat_left_q <= pat_left_q - 1'b1;
                if (budget_end && seed_idx_q != 2'd2) begin
                    seed_idx_q <= seed_idx_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        seed_ready = 1'b0;
        scan_en    = 1'b0;
        capture    = 1'b0;
        all_done   = 1'b0;
        unique case (state_q)
            ST_WAIT_SEED: seed_ready = 1'b1;
            ST_SHIFT:     scan_en    = 1'b1;
            ST_CAPT:      capture    = 1'b1;
            ST_DONE:      all_done   = 1'b1;
            default:      ;
        endcase
        scan_in  = chain_bits;
        pat_done = pdone_q;
        seed_err = err_q;
    end

endmodule

// File: rtl/mmbist_seed_ctrl_chk.sv
module mmbist_seed_ctrl_chk #(
    parameter int LFSR_W    = 96,
    parameter int SHIFT_LEN = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              seed_valid,
    input logic [LFSR_W-1:0] seed_data,
    input logic              seed_ready,
    input logic              scan_en,
    input logic              capture,
    input logic              pat_done,
    input logic              seed_err,
    input logic              all_done
);

    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (scan_en) begin
            run_cnt <= run_cnt + 1;
        end else if (capture) begin
            run_cnt <= 0;
        end
    end

    // R6
    shift_capture_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && capture));

    // R6
    shift_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (run_cnt == SHIFT_LEN));

    // R6
    pat_done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> pat_done);

    // R6
    pat_done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_done |-> $past(capture));

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ready |-> (!scan_en && !capture && !all_done));

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_ready && seed_valid && seed_data != '0) |=> (!seed_ready && scan_en));

    // R9
    zero_seed_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_ready && seed_valid && seed_data == '0) |=> (!scan_en && seed_err));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_err && !start) |=> seed_err);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_done && !start) |=> (all_done && !seed_ready));

endmodule

bind mmbist_seed_ctrl mmbist_seed_ctrl_chk #(
    .LFSR_W    (LFSR_W),
    .SHIFT_LEN (SHIFT_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .seed_valid (seed_valid),
    .seed_data  (seed_data),
    .seed_ready (seed_ready),
    .scan_en    (scan_en),
    .capture    (capture),
    .pat_done   (pat_done),
    .seed_err   (seed_err),
    .all_done   (all_done)
);

// File: tb/mmbist_seed_ctrl_bench.sv
module mmbist_seed_ctrl_bench;

    localparam int          W      = 16;
    localparam int          CH     = 4;
    localparam int          CW     = 13;
    localparam logic [15:0] TAPS_B = 16'hB400;
    localparam int          SLEN   = (W + CH - 1) / CH;
    localparam int          STR    = W / CH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] depth = '0;
    logic          seed_valid = 1'b0;
    logic [W-1:0]  seed_data = '0;
    logic          seed_last = 1'b0;
    logic          seed_ready;
    logic [CH-1:0] scan_in;
    logic          scan_en;
    logic          capture;
    logic          pat_done;
    logic          seed_err;
    logic          all_done;

    int n_chk = 0;
    int n_err = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;

    mmbist_seed_ctrl #(.LFSR_W(W), .CHAINS(CH), .CNT_W(CW), .TAPS(TAPS_B)) u_mmbist_seed_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .depth(depth),
        .seed_valid(seed_valid), .seed_data(seed_data), .seed_last(seed_last),
        .seed_ready(seed_ready), .scan_in(scan_in), .scan_en(scan_en),
        .capture(capture), .pat_done(pat_done), .seed_err(seed_err), .all_done(all_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & TAPS_B)};
    endfunction

    function automatic logic [CH-1:0] spread(input logic [W-1:0] s);
        logic [CH-1:0] r;
        for (int c = 0; c < CH; c++) r[c] = s[c*STR] ^ s[W-1-c*STR];
        return r;
    endfunction

    function automatic int exp_pats(input int m, input int d, input int i);
        int de;
        de = (d == 0) ? 1 : d;
        case (m)
            1:       return (i == 0) ? de : 1;
            2:       return (i < 2) ? de : 1;
            default: return de;
        endcase
    endfunction

    // independent model state and monitor counters
    logic [W-1:0] model = '0;
    int  pats [0:15];
    int  nseeds = 0;
    int  run = 0;
    int  lf_err = 0;
    int  fr_err = 0;
    int  rd_err = 0;
    int  pd_err = 0;
    bit  cap_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scan_en) begin
                if (scan_in !== spread(model)) lf_err++;   // R7
                run++;
            end else if (scan_in !== '0) begin
                lf_err++;
            end
            if (capture) begin
                if (run != SLEN || scan_en) fr_err++;      // R6
                run = 0;
                if (nseeds > 0) pats[nseeds-1]++;
            end
            if (pat_done !== cap_prev) pd_err++;           // R6
            cap_prev = capture;
            if (seed_ready && (scan_en || capture || all_done)) rd_err++; // R8
            if (scan_en) model = lfsr_step(model);
            if (seed_valid && seed_ready && seed_data != '0) begin
                pats[nseeds] = 0;
                nseeds++;
                model = seed_data;
            end
        end
    end

    logic [W-1:0] seeds_q [0:7];

    task automatic send_seed(input logic [W-1:0] s, input bit last);
        @(posedge clk); #1;
        seed_valid = 1'b1; seed_data = s; seed_last = last;
        forever begin
            @(negedge clk);
            if (seed_ready) break;
        end
        @(posedge clk); #1;
        seed_valid = 1'b0; seed_data = '0; seed_last = 1'b0;
    endtask

    task automatic pulse_start(input int m, input int d);
        @(posedge clk); #1;
        start = 1'b1; mode = 2'(m); depth = CW'(d);
        @(posedge clk); #1;
        start = 1'b0;
        mode  = ~mode;          // R2: later changes ignored
        depth = depth + 13'd3;
    endtask

    task automatic run_session(input int m, input int d, input int n, input int nz, input bit exp_err);
        int w;
        nseeds = 0; lf_err = 0; fr_err = 0; rd_err = 0; pd_err = 0;
        pulse_start(m, d);
        @(negedge clk);
        chk(seed_ready == 1'b1, "R2 ready after start", int'(seed_ready), 1);
        chk(all_done == 1'b0, "R10 done cleared by start", int'(all_done), 0);
        chk(seed_err == 1'b0, "R9 err cleared by start", int'(seed_err), 0);
        for (int i = 0; i < n; i++) send_seed(seeds_q[i], i == n - 1);
        w = 0;
        while (!all_done && w < 60000) begin
            @(negedge clk); w++;
        end
        chk(all_done == 1'b1, "R10 all_done raised", int'(all_done), 1);
        chk(nseeds == nz, "R9 nonzero seeds loaded", nseeds, nz);
        for (int i = 0; i < nseeds; i++)
            chk(pats[i] == exp_pats(m, d, i), $sformatf("R3/R4/R5 mode %0d seed %0d pattern count", m, i),
                pats[i], exp_pats(m, d, i));
        chk(lf_err == 0, "R7 scan_in vs LFSR model", lf_err, 0);
        chk(fr_err == 0, "R6 shift frame length", fr_err, 0);
        chk(pd_err == 0, "R6 pat_done timing", pd_err, 0);
        chk(rd_err == 0, "R8 ready exclusive", rd_err, 0);
        chk(seed_err == exp_err, "R9 seed_err state", int'(seed_err), int'(exp_err));
        repeat (5) @(negedge clk);
        chk(all_done == 1'b1 && seed_ready == 1'b0, "R10 done held", int'(all_done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(seed_ready == 1'b0, "R1 seed_ready", int'(seed_ready), 0);
        chk(scan_en == 1'b0 && capture == 1'b0, "R1 scan_en/capture", int'({scan_en, capture}), 0);
        chk(all_done == 1'b0 && seed_err == 1'b0 && pat_done == 1'b0, "R1 flags",
            int'({all_done, seed_err, pat_done}), 0);
        chk(scan_in == '0, "R1 scan_in", int'(scan_in), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(seed_ready == 1'b0, "R1 idle without start", int'(seed_ready), 0);

        seeds_q[0] = 16'hACE1; seeds_q[1] = 16'h1234; seeds_q[2] = 16'h8001;
        seeds_q[3] = 16'h0F0F; seeds_q[4] = 16'h5A5A;
        // R3: uniform sweep incl. depth 0
        for (int d = 0; d <= 8; d++) begin
            if (d == 0 || d == 1 || d == 2 || d == 4 || d == 8) run_session(0, d, 3, 3, 1'b0);
        end
        // R3: reserved encoding acts as uniform
        run_session(3, 2, 2, 2, 1'b0);
        // R4
        run_session(1, 1024, 3, 3, 1'b0);
        run_session(1, 4096, 2, 2, 1'b0);
        // R5
        run_session(2, 2048, 4, 4, 1'b0);
        run_session(2, 1024, 5, 5, 1'b0);
        // R9: zero seed skipped, does not take first position
        seeds_q[0] = 16'h0000; seeds_q[1] = 16'hBEEF; seeds_q[2] = 16'h0000; seeds_q[3] = 16'h7001;
        run_session(1, 4, 4, 2, 1'b1);
        // R11: zero seed marked last ends the session
        seeds_q[0] = 16'h4321; seeds_q[1] = 16'h0000;
        run_session(0, 2, 2, 1, 1'b1);
        chk(pats[0] == 2, "R11 no extra pattern", pats[0], 2);
        // R9/R10: new start clears sticky flags
        pulse_start(0, 1);
        @(negedge clk);
        chk(seed_err == 1'b0 && all_done == 1'b0, "R9 R10 cleared on restart",
            int'({seed_err, all_done}), 0);
        finish_run();
    end

endmodule